// File: doc/BRIEF.md
# Coalescing Store Buffer with Split Tag and Data Drain

This block holds committed stores on their way to a write-through cache hierarchy. Each store carries a byte address, a 64-bit datum and eight byte enables. It lands in one of eight entries, and each entry covers one aligned 16-byte block. A store that hits the same block as the youngest entry merges into that entry, as long as the youngest entry has not yet finished its tag check. Merged stores leave the buffer as a single data write with the union of their byte enables.

Each entry drains in two phases.

- **Tag phase:** a tag lookup is made against the 64-byte line. The lookup is skipped when the line matches the last line that was confirmed present.
- **Data phase:** a write of the whole 16-byte block follows later.

The tag phase and the data phase run from separate pointers. A younger entry's tag lookup can therefore be granted in the same cycle as an older entry's data write. This lets the buffer drain one store per clock.

When a tag lookup misses, the buffer waits for a fill-complete pulse. Only then does it allow the data write of that entry and resume tag lookups.

Top module: `store_coalesce_buf`

## Requirements
- R1: In the cycle after a synchronous reset, the buffer is empty. `wr_req`, `tag_req` and `st_stall` are all low.
- R2: Data writes leave in the order in which their entries were allocated. Each allocated entry produces exactly one write of its 16-byte block address (`st_addr[31:4]`). While `wr_req` is high without `wr_gnt`, the block address, enables and data stay unchanged.
- R3: A store merges into the youngest entry instead of allocating a new one when both of these hold: its block matches that entry's block, and that entry's tag phase is not complete. Byte lane placement works as follows:
  - `st_addr[3]=0` maps the store to bytes 0-7 of the block; `st_addr[3]=1` maps it to bytes 8-15.
  - Enables are ORed.
  - On an overlapping byte, the newer store's value wins.
- R4: A store to the block of an entry whose tag phase has completed allocates a new entry. The result is a separate data write.
- R5: `st_stall` is high when all eight entries are occupied and the presented store cannot merge. A stalled store is not taken. A store that can merge is taken even when all eight entries are occupied.
- R6: An entry whose line differs from the last confirmed line raises `tag_req` with `tag_line = st_addr[31:6]`. The request and `tag_line` hold until `tag_gnt`. The lookup result is `tag_hit`, sampled with the grant.
- R7: An entry whose line equals the last line that hit, or the last line that was filled, completes its tag phase without raising `tag_req`.
- R8: A tag grant for a younger entry and a data write grant for an older entry can occur in the same cycle. With both grants held high, back-to-back stores to distinct lines produce one data write per clock.
- R9: After a miss, the missing entry is not written, and no further `tag_req` is raised, until `fill_done` pulses. A `fill_done` pulse while no miss is pending has no effect.
- R10: `wr_req` is raised only for an entry whose tag phase has completed. No write appears for a store that was not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store is presented |
| st_addr | input | 32 | Byte address of the store (low 3 bits ignored) |
| st_data | input | 64 | Store datum |
| st_be | input | 8 | Byte enables of the datum |
| st_stall | output | 1 | Presented store cannot be taken this cycle |
| tag_req | output | 1 | Tag lookup request |
| tag_line | output | 26 | 64-byte line address for the lookup |
| tag_gnt | input | 1 | Tag lookup performed this cycle |
| tag_hit | input | 1 | Lookup result, valid with `tag_gnt` |
| fill_done | input | 1 | Single-cycle pulse: missing line has been filled |
| wr_req | output | 1 | Data write request for the oldest entry |
| wr_blk | output | 28 | 16-byte block address of the write |
| wr_data | output | 128 | Block data |
| wr_be | output | 16 | Byte enables of the block |
| wr_gnt | input | 1 | Data write accepted this cycle |

## Verification
The assertions assume that the cache side behaves as a well-formed responder:

- `tag_hit` is meaningful only together with `tag_gnt`.
- `fill_done` matters only after a granted miss.
- The store side keeps a stalled store presented or withdraws it, without relying on it being taken.

The stimulus raises grants only as single-cycle or steady levels set between clock edges. It pulses `fill_done` once per miss, plus one deliberate stray pulse with nothing outstanding. It never presents a store whose acceptance it has not planned: it either expects a merge, expects a fresh entry, or expects a stall.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Kind of update applied to the entry storage in a cycle
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ALLOC = 2'd1,
    WK_MERGE = 2'd2
  } sbuf_wkind_e;

endpackage

// File: rtl/sbuf_lane_ram.sv
module sbuf_lane_ram
  import sbuf_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int BLK_BYTES = 16
) (
  input  logic                       clk,
  input  sbuf_wkind_e                wkind,
  input  logic [$clog2(DEPTH)-1:0]   widx,
  input  logic [BLK_BYTES-1:0]       wbe,
  input  logic [8*BLK_BYTES-1:0]     wdata,
  input  logic [$clog2(DEPTH)-1:0]   ridx,
  output logic [8*BLK_BYTES-1:0]     rdata,
  output logic [BLK_BYTES-1:0]       rbe
);

  logic [BLK_BYTES-1:0] be_q [DEPTH];

  // One narrow memory per byte lane so each maps to its own RAM slice
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wkind != WK_IDLE && wbe[g]) begin
        lane_mem[widx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = lane_mem[ridx];
  end

  // Enables: fresh on allocation, accumulated on merge
  always_ff @(posedge clk) begin
    if (wkind == WK_ALLOC) begin
      be_q[widx] <= wbe;
    end else if (wkind == WK_MERGE) begin
      be_q[widx] <= be_q[widx] | wbe;
    end
  end

  assign rbe = be_q[ridx];

endmodule

// File: rtl/sbuf_queue.sv
module sbuf_queue
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BAW   = 28
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [BAW-1:0]            in_blk,
  input  logic                      chk_done,
  input  logic                      rdy_set,
  input  logic [$clog2(DEPTH)-1:0]  rdy_idx,
  input  logic                      wr_gnt,
  output logic                      stall,
  output sbuf_wkind_e               wkind,
  output logic [$clog2(DEPTH)-1:0]  widx,
  output logic [$clog2(DEPTH)-1:0]  head_idx,
  output logic                      wr_req,
  output logic [BAW-1:0]            head_blk,
  output logic [$clog2(DEPTH)-1:0]  chk_idx,
  output logic                      chk_pending,
  output logic [BAW-1:0]            chk_blk
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [BAW-1:0] blk_q [DEPTH];
  logic [DEPTH-1:0] rdy_q;
  logic [PW-1:0] head_q, tail_q, chk_q, young;
  logic [CW-1:0] cnt_q, nchk_q;
  logic merge_ok, full, push, pop;

  function automatic logic [PW-1:0] step_fwd(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] step_back(input logic [PW-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  assign young    = step_back(tail_q);
  assign full     = (cnt_q == FULL_CNT);
  // Merge only into the youngest entry while its tag phase is still open
  assign merge_ok = in_valid && (cnt_q > nchk_q) && (blk_q[young] == in_blk);
  assign stall    = full && !merge_ok;
  assign push     = in_valid && !merge_ok && !full;
  assign wr_req   = (cnt_q != '0) && rdy_q[head_q];
  assign pop      = wr_req && wr_gnt;

  always_comb begin
    wkind = WK_IDLE;
    widx  = tail_q;
    if (merge_ok) begin
      wkind = WK_MERGE;
      widx  = young;
    end else if (push) begin
      wkind = WK_ALLOC;
    end
  end

  assign head_idx    = head_q;
  assign head_blk    = blk_q[head_q];
  assign chk_idx     = chk_q;
  assign chk_pending = (cnt_q > nchk_q);
  assign chk_blk     = blk_q[chk_q];

  always_ff @(posedge clk) begin
    if (push) begin
      blk_q[tail_q] <= in_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      chk_q  <= '0;
      cnt_q  <= '0;
      nchk_q <= '0;
    end else begin
      if (push) begin
        rdy_q[tail_q] <= 1'b0;
        tail_q        <= step_fwd(tail_q);
      end
      if (pop) begin
        rdy_q[head_q] <= 1'b0;
        head_q        <= step_fwd(head_q);
      end
      if (rdy_set) begin
        rdy_q[rdy_idx] <= 1'b1;
      end
      if (chk_done) begin
        chk_q <= step_fwd(chk_q);
      end
      cnt_q  <= cnt_q + CW'(push) - CW'(pop);
      nchk_q <= nchk_q + CW'(chk_done) - CW'(pop);
    end
  end

  // R10: the oldest entry may only be written once its tag phase is complete
  a_r10_write_only_checked: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (nchk_q != '0));

  // R5: occupancy never exceeds the entry count, checked never exceeds occupied
  a_r5_occupancy: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= FULL_CNT) && (nchk_q <= cnt_q));

  // R9: an entry is released for writing only once
  a_r9_ready_set_once: assert property (@(posedge clk) disable iff (rst)
    rdy_set |-> !rdy_q[rdy_idx]);

  // R3/R4: a merge never allocates a new entry
  a_r4_merge_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (wkind == WK_MERGE) |=> (cnt_q == $past(cnt_q) - CW'($past(pop))));

endmodule

// File: rtl/sbuf_tagseq.sv
module sbuf_tagseq #(
  parameter int DEPTH = 8,
  parameter int BAW   = 28,
  parameter int LAW   = 26
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      chk_pending,
  input  logic [$clog2(DEPTH)-1:0]  chk_idx,
  input  logic [BAW-1:0]            chk_blk,
  input  logic                      tag_gnt,
  input  logic                      tag_hit,
  input  logic                      fill_done,
  output logic                      tag_req,
  output logic [LAW-1:0]            tag_line,
  output logic                      chk_done,
  output logic                      rdy_set,
  output logic [$clog2(DEPTH)-1:0]  rdy_idx
);

  localparam int PW = $clog2(DEPTH);
  localparam int SH = BAW - LAW;

  logic [LAW-1:0] last_line_q;
  logic           last_ok_q;
  logic           wait_q;
  logic [PW-1:0]  wait_idx_q;
  logic           reuse, granted, fill_ok;
  logic           unused_blk_low;

  assign unused_blk_low = ^chk_blk[SH-1:0];
  assign tag_line = chk_blk[BAW-1:SH];

  // Skip the lookup when the line was last confirmed present
  assign reuse    = chk_pending && !wait_q && last_ok_q && (tag_line == last_line_q);
  assign tag_req  = chk_pending && !wait_q && !reuse;
  assign granted  = tag_req && tag_gnt;
  assign chk_done = reuse || granted;
  assign fill_ok  = wait_q && fill_done;
  assign rdy_set  = reuse || (granted && tag_hit) || fill_ok;
  assign rdy_idx  = wait_q ? wait_idx_q : chk_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_line_q <= '0;
      last_ok_q   <= 1'b0;
      wait_q      <= 1'b0;
      wait_idx_q  <= '0;
    end else if (granted) begin
      last_line_q <= tag_line;
      last_ok_q   <= tag_hit;
      wait_q      <= !tag_hit;
      wait_idx_q  <= chk_idx;
    end else if (fill_ok) begin
      wait_q    <= 1'b0;
      last_ok_q <= 1'b1;
    end
  end

  // R6: an ungranted lookup stays requested for the same line
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (tag_req && !tag_gnt) |=> (tag_req && $stable(tag_line)));

endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf
  import sbuf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int DW         = 64,
  parameter int BLK_BYTES  = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  st_valid,
  input  logic [AW-1:0]                         st_addr,
  input  logic [DW-1:0]                         st_data,
  input  logic [DW/8-1:0]                       st_be,
  output logic                                  st_stall,
  output logic                                  tag_req,
  output logic [AW-$clog2(LINE_BYTES)-1:0]      tag_line,
  input  logic                                  tag_gnt,
  input  logic                                  tag_hit,
  input  logic                                  fill_done,
  output logic                                  wr_req,
  output logic [AW-$clog2(BLK_BYTES)-1:0]       wr_blk,
  output logic [8*BLK_BYTES-1:0]                wr_data,
  output logic [BLK_BYTES-1:0]                  wr_be,
  input  logic                                  wr_gnt
);

  localparam int SB    = DW / 8;
  localparam int SOFF  = $clog2(SB);
  localparam int BOFF  = $clog2(BLK_BYTES);
  localparam int LOFF  = $clog2(LINE_BYTES);
  localparam int NSLOT = BLK_BYTES / SB;
  localparam int SLW   = BOFF - SOFF;
  localparam int BAW   = AW - BOFF;
  localparam int LAW   = AW - LOFF;
  localparam int PW    = $clog2(DEPTH);

  logic [SLW-1:0]         slot;
  logic [BAW-1:0]         in_blk;
  logic [BLK_BYTES-1:0]   lane_be;
  logic [8*BLK_BYTES-1:0] lane_data;
  logic                   unused_addr_low;

  sbuf_wkind_e   wkind;
  logic [PW-1:0] widx, head_idx, chk_idx, rdy_idx;
  logic          chk_pending, chk_done, rdy_set;
  logic [BAW-1:0] chk_blk;

  assign unused_addr_low = ^st_addr[SOFF-1:0];
  assign slot      = st_addr[BOFF-1:SOFF];
  assign in_blk    = st_addr[AW-1:BOFF];
  assign lane_be   = {{(BLK_BYTES-SB){1'b0}}, st_be} << {slot, {SOFF{1'b0}}};
  assign lane_data = {NSLOT{st_data}};

  sbuf_queue #(.DEPTH(DEPTH), .BAW(BAW)) u_queue (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (st_valid),
    .in_blk      (in_blk),
    .chk_done    (chk_done),
    .rdy_set     (rdy_set),
    .rdy_idx     (rdy_idx),
    .wr_gnt      (wr_gnt),
    .stall       (st_stall),
    .wkind       (wkind),
    .widx        (widx),
    .head_idx    (head_idx),
    .wr_req      (wr_req),
    .head_blk    (wr_blk),
    .chk_idx     (chk_idx),
    .chk_pending (chk_pending),
    .chk_blk     (chk_blk)
  );

  sbuf_tagseq #(.DEPTH(DEPTH), .BAW(BAW), .LAW(LAW)) u_tagseq (
    .clk         (clk),
    .rst         (rst),
    .chk_pending (chk_pending),
    .chk_idx     (chk_idx),
    .chk_blk     (chk_blk),
    .tag_gnt     (tag_gnt),
    .tag_hit     (tag_hit),
    .fill_done   (fill_done),
    .tag_req     (tag_req),
    .tag_line    (tag_line),
    .chk_done    (chk_done),
    .rdy_set     (rdy_set),
    .rdy_idx     (rdy_idx)
  );

  sbuf_lane_ram #(.DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES)) u_ram (
    .clk   (clk),
    .wkind (wkind),
    .widx  (widx),
    .wbe   (lane_be),
    .wdata (lane_data),
    .ridx  (head_idx),
    .rdata (wr_data),
    .rbe   (wr_be)
  );

  // R2: a waiting write keeps its block, enables and data until granted
  a_r2_head_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_blk) && $stable(wr_be) && $stable(wr_data)));

endmodule

// File: tb/store_coalesce_buf_tb.sv
module store_coalesce_buf_tb;

  localparam int BAW = 28;
  localparam int LAW = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           st_valid = 1'b0;
  logic [31:0]    st_addr = '0;
  logic [63:0]    st_data = '0;
  logic [7:0]     st_be = '0;
  logic           st_stall, tag_req, wr_req;
  logic [LAW-1:0] tag_line;
  logic           tag_gnt = 1'b0, tag_hit = 1'b1, fill_done = 1'b0, wr_gnt = 1'b0;
  logic [BAW-1:0] wr_blk;
  logic [127:0]   wr_data;
  logic [15:0]    wr_be;

  store_coalesce_buf u_dut (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_stall(st_stall), .tag_req(tag_req), .tag_line(tag_line),
    .tag_gnt(tag_gnt), .tag_hit(tag_hit), .fill_done(fill_done), .wr_req(wr_req),
    .wr_blk(wr_blk), .wr_data(wr_data), .wr_be(wr_be), .wr_gnt(wr_gnt)
  );

  int n_checks = 0, n_errors = 0;
  int cyc = 0;
  int n_wr = 0, n_tagreq = 0, n_overlap = 0;
  int wr_cyc [256];
  logic [BAW-1:0] e_blk [256];
  logic [127:0]   e_dat [256];
  logic [15:0]    e_be  [256];
  int eh = 0, et = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] be_mask(input logic [15:0] be);
    logic [127:0] m = '0;
    for (int k = 0; k < 16; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  // Write monitor: compares every granted write against the bench model
  always @(negedge clk) begin
    if (!rst) begin
      if (tag_req) n_tagreq++;
      if (tag_req && tag_gnt && wr_req && wr_gnt) n_overlap++;
      if (wr_req && wr_gnt) begin
        wr_cyc[n_wr % 256] = cyc;
        n_wr++;
        if (eh == et) begin
          check(1'b0, "R10 write with no store outstanding", 128'(wr_blk), '0);
        end else begin
          check(wr_blk == e_blk[eh % 256], "R2 write order block", 128'(wr_blk), 128'(e_blk[eh % 256]));
          check(wr_be == e_be[eh % 256], "R3 merged enables", 128'(wr_be), 128'(e_be[eh % 256]));
          check((wr_data & be_mask(wr_be)) == (e_dat[eh % 256] & be_mask(e_be[eh % 256])),
                "R3 merged data", wr_data & be_mask(wr_be), e_dat[eh % 256] & be_mask(e_be[eh % 256]));
          eh++;
        end
      end
    end
  end

  task automatic model_add(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be, input bit merge);
    int idx;
    if (!merge) begin
      e_blk[et % 256] = a[31:4];
      e_be[et % 256]  = '0;
      e_dat[et % 256] = '0;
      et++;
    end
    for (int k = 0; k < 8; k++) begin
      if (be[k]) begin
        idx = (a[3] ? 8 : 0) + k;
        e_be[(et-1) % 256][idx] = 1'b1;
        e_dat[(et-1) % 256][8*idx +: 8] = d[8*k +: 8];
      end
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be, input bit merge, input string req);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    @(negedge clk);
    check(!st_stall, req, 128'(st_stall), '0);
    model_add(a, d, be, merge);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && eh != et; i++) idle(1);
    check(eh == et, req, 128'(et - eh), '0);
    idle(2);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int w0, t0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!wr_req && !tag_req && !st_stall, "R1 reset state", {wr_req, tag_req, st_stall}, '0);
    @(posedge clk); #1;

    // Scenario A: merging into one entry, lookup request for a new line
    w0 = n_wr;
    push(32'h1000, 64'h1111_2222_3333_4444, 8'hFF, 0, "R3 first store");
    push(32'h1008, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F, 1, "R3 upper half merge");
    push(32'h1000, 64'h5555_6666_7777_8888, 8'h30, 1, "R3 overwrite merge");
    push(32'h1000, 64'h99AA_BBCC_DDEE_FF00, 8'h81, 1, "R3 overwrite merge");
    push(32'h2000, 64'h0123_4567_89AB_CDEF, 8'hF0, 0, "R3 new block");
    @(negedge clk);
    check(tag_req && tag_line == 26'h40, "R6 lookup of first line", 128'(tag_line), 128'h40);
    check(!wr_req, "R10 no write before lookup", 128'(wr_req), '0);
    idle(2);
    @(negedge clk);
    check(tag_req && tag_line == 26'h40, "R6 request held", 128'(tag_line), 128'h40);
    @(posedge clk); #1;
    tag_gnt = 1'b1; wr_gnt = 1'b1;
    drain("R2 scenario A drained");
    check(n_wr - w0 == 2, "R3 merged stores give one write", 128'(n_wr - w0), 128'd2);

    // Scenario B: lookup reuse and no merge into a checked entry
    tag_gnt = 1'b0; wr_gnt = 1'b0; w0 = n_wr; t0 = n_tagreq;
    push(32'h2010, 64'hDEAD_BEEF_0000_1111, 8'h0F, 0, "R7 store to confirmed line");
    idle(1);
    push(32'h2010, 64'hCAFE_F00D_2222_3333, 8'hF0, 0, "R4 store to checked block");
    idle(3);
    @(negedge clk);
    check(n_tagreq == t0, "R7 no lookup for confirmed line", 128'(n_tagreq - t0), '0);
    check(wr_req && wr_blk == 28'h201, "R7 write ready without lookup", 128'(wr_blk), 128'h201);
    @(posedge clk); #1;
    wr_gnt = 1'b1;
    drain("R4 scenario B drained");
    check(n_wr - w0 == 2, "R4 checked entry not merged", 128'(n_wr - w0), 128'd2);

    // Scenario C: fill all entries, stall, merge while full
    tag_gnt = 1'b0; wr_gnt = 1'b0; w0 = n_wr;
    for (int i = 0; i < 8; i++)
      push(32'h4000 + 32'(i) * 32'h40, {32'(i), 32'hF00D0000 + 32'(i)}, 8'hFF, 0, "R5 fill entry");
    st_valid = 1'b1; st_addr = 32'h9000; st_data = 64'h7777; st_be = 8'hFF;
    @(negedge clk);
    check(st_stall, "R5 stall when full without merge", 128'(st_stall), 128'd1);
    @(posedge clk); #1;
    push(32'h41C8, 64'h4242_4242_4242_4242, 8'h3C, 1, "R5 merge accepted while full");
    tag_gnt = 1'b1; wr_gnt = 1'b1;
    drain("R2 scenario C drained");
    check(n_wr - w0 == 8, "R5 stalled store not taken", 128'(n_wr - w0), 128'd8);

    // Scenario D: miss, stray fill pulse, fill completion
    tag_gnt = 1'b0; wr_gnt = 1'b1; w0 = n_wr;
    fill_done = 1'b1; idle(1); fill_done = 1'b0;
    push(32'hA000, 64'h1357_9BDF_0246_8ACE, 8'hFF, 0, "R9 store to missing line");
    @(negedge clk);
    check(tag_req && tag_line == 26'h280, "R9 stray fill has no effect", 128'(tag_line), 128'h280);
    @(posedge clk); #1;
    tag_hit = 1'b0; tag_gnt = 1'b1;
    idle(1);
    tag_hit = 1'b1; tag_gnt = 1'b0;
    push(32'hA040, 64'h0F0F_0F0F_F0F0_F0F0, 8'h0F, 0, "R9 store behind miss");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!wr_req && !tag_req, "R9 held until fill", {wr_req, tag_req}, '0);
      @(posedge clk); #1;
    end
    fill_done = 1'b1; idle(1); fill_done = 1'b0;
    @(negedge clk);
    check(tag_req && tag_line == 26'h281, "R9 lookups resume after fill", 128'(tag_line), 128'h281);
    @(posedge clk); #1;
    tag_gnt = 1'b1;
    drain("R9 scenario D drained");
    check(n_wr - w0 == 2, "R9 both stores written", 128'(n_wr - w0), 128'd2);

    // Scenario E: sustained one store per clock with overlapped grants
    tag_gnt = 1'b1; wr_gnt = 1'b1; w0 = n_wr; t0 = n_overlap;
    for (int i = 0; i < 16; i++)
      push(32'h20000 + 32'(i) * 32'h40, {32'hBEEF0000 + 32'(i), 32'(i * 3)}, 8'hFF, 0, "R8 no stall at full rate");
    drain("R8 scenario E drained");
    for (int i = 1; i < 16; i++)
      check(wr_cyc[(w0 + i) % 256] - wr_cyc[(w0 + i - 1) % 256] == 1, "R8 one write per clock",
            128'(wr_cyc[(w0 + i) % 256] - wr_cyc[(w0 + i - 1) % 256]), 128'd1);
    check(n_overlap - t0 >= 14, "R8 lookup and write in same cycle", 128'(n_overlap - t0), 128'd14);

    // Scenario F: merge sweep over lanes and enable patterns
    for (int b = 0; b < 4; b++) begin
      tag_gnt = 1'b0; wr_gnt = 1'b0; w0 = n_wr;
      for (int i = 0; i < 12; i++) begin
        logic [7:0] be;
        be = 8'(i * 37 + b * 11 + 1);
        if (be == 8'h00) be = 8'h01;
        push(32'h30000 + 32'(b) * 32'h100 + ((i % 2 == 1) ? 32'h8 : 32'h0),
             {8{8'(i * 17 + b * 5 + 1)}} ^ (64'(i) << 20), be, i != 0, "R3 sweep store");
      end
      tag_gnt = 1'b1; wr_gnt = 1'b1;
      drain("R3 sweep drained");
      check(n_wr - w0 == 1, "R3 sweep single write", 128'(n_wr - w0), 128'd1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule